// File: doc/BRIEF.md
# Three-Class Interrupt Entry and Return Unit

This unit runs the entry and return sequence of a processor for three interrupt classes. The classes are noncritical, critical and machine check. Raw interrupt lines are passed through a synchronizer and then qualified by per-class enable bits taken from the machine-state word. A class that is already being serviced is held back. The highest remaining class is granted.

The sequencer then empties the instruction queue. If the oldest queued instruction is a load/store, it first opens a fixed drain window so that completing memory operations can retire. It then captures the resume PC and the machine state into that class's own save pair. Finally it requests the handler fetch with a class code and writes back a machine state with the relevant enables cleared.

Each class has its own return strobe. The strobe restores PC and machine state from that class's pair only, and it frees the class for a new entry.

Top module: `trap_entry_unit`

## Requirements
- R1: An interrupt line passes a 2-flop synchronizer. With `oldest_is_ls` low when the request is sampled, `vec_req` is high for one cycle exactly 5 clocks after the raw line is raised, which is 3 clocks of entry latency.
- R2: With `oldest_is_ls` high when the request is sampled, `ls_drain` is high for exactly 4 consecutive cycles and `vec_req` follows 9 clocks after the raw line is raised, which is 7 clocks of entry latency.
- R3: `flush` is high for exactly one cycle per entry, two cycles before `vec_req`, and never while `ls_drain` is high.
- R4: Machine check outranks critical, and critical outranks noncritical. `vec_class` reads 2'b00 for noncritical, 2'b01 for critical and 2'b10 for machine check.
- R5: `cur_msr` bit 0 enables noncritical, bit 1 enables critical and bit 2 enables machine check. A disabled class is never entered.
- R6: On entry, the granted class's save pair takes the `cur_pc` and `cur_msr` values present in the cycle before `vec_req`. The save pairs of the other classes keep their values.
- R7: In the `vec_req` cycle, `msr_wr` is high and `msr_new` equals the saved machine state with bits cleared: bit 0 for noncritical, bits 1:0 for critical, bits 2:0 for machine check.
- R8: A class that has been entered is not entered again until its own return strobe. `in_svc` shows one bit per class, in the order of the class code.
- R9: A return strobe seen while idle produces, one cycle later, a one-cycle `pc_wr` and `msr_wr`. At that point `pc_new` and `msr_new` hold that class's saved pair and its `in_svc` bit is cleared.
- R10: Return strobes seen while `busy` is high are ignored. No `pc_wr` follows, and `in_svc` is unchanged.
- R11: A higher class raised during a lower class's entry is taken after that entry completes. Its `vec_req` comes 4 clocks after the lower one's.
- R12: A return strobe in the same idle cycle as the sampling of a new request is honored, and the entry proceeds with its normal latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_nc_in | input | 1 | Raw noncritical request line |
| irq_cr_in | input | 1 | Raw critical request line |
| irq_mc_in | input | 1 | Raw machine-check request line |
| oldest_is_ls | input | 1 | Oldest queued instruction is a load/store |
| cur_pc | input | AW | Current resume address |
| cur_msr | input | MW | Current machine-state word |
| ret_nc | input | 1 | Return strobe, noncritical |
| ret_cr | input | 1 | Return strobe, critical |
| ret_mc | input | 1 | Return strobe, machine check |
| busy | output | 1 | Entry sequence in progress |
| ls_drain | output | 1 | Load/store drain window open |
| flush | output | 1 | Discard instruction queue |
| vec_req | output | 1 | Handler fetch request |
| vec_class | output | 2 | Class code of the request |
| in_svc | output | 3 | Per-class in-service flags |
| nc_save_pc | output | AW | Noncritical saved address |
| nc_save_msr | output | MW | Noncritical saved state |
| cr_save_pc | output | AW | Critical saved address |
| cr_save_msr | output | MW | Critical saved state |
| mc_save_pc | output | AW | Machine-check saved address |
| mc_save_msr | output | MW | Machine-check saved state |
| pc_wr | output | 1 | Restore PC strobe |
| pc_new | output | AW | Restored PC |
| msr_wr | output | 1 | Machine-state write strobe |
| msr_new | output | MW | Machine-state value to write |

## Verification
A return strobe and the sampling of a fresh request can fall in the same idle cycle. One frees a class and restores state, while the other starts a new entry. The bench provokes this case directly. It puts the critical class in service, raises the noncritical line, and pulses the critical return exactly two clocks later, when the synchronized request is sampled. It then judges both outcomes: the restore strobe must carry the critical pair one clock later, and the noncritical handler request must still arrive at the fifth clock after the raw line, with `flush` in between.

// File: rtl/trap_pkg.sv
package trap_pkg;

  localparam int NCLS = 3;

  // machine-state bit positions for the class enables
  localparam int EN_NC = 0;
  localparam int EN_CR = 1;
  localparam int EN_MC = 2;

  typedef enum logic [1:0] {
    CLS_NC = 2'b00,
    CLS_CR = 2'b01,
    CLS_MC = 2'b10
  } trap_cls_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_FLUSH,
    ST_SAVE,
    ST_ISSUE
  } seq_st_e;

  // highest set bit as a one-hot vector (index 2 ranks first)
  function automatic logic [NCLS-1:0] pick_high(input logic [NCLS-1:0] v);
    if (v[2])      return 3'b100;
    else if (v[1]) return 3'b010;
    else if (v[0]) return 3'b001;
    else           return 3'b000;
  endfunction

  function automatic trap_cls_e grant_to_cls(input logic [NCLS-1:0] g);
    if (g[2])      return CLS_MC;
    else if (g[1]) return CLS_CR;
    else           return CLS_NC;
  endfunction

  function automatic logic [NCLS-1:0] cls_onehot(input trap_cls_e c);
    return 3'b001 << c;
  endfunction

  // enables dropped on entry: the class itself and every lower class
  function automatic logic [NCLS-1:0] en_mask_for(input trap_cls_e c);
    case (c)
      CLS_NC:  return 3'b001;
      CLS_CR:  return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

  // clocks from sampling to handler fetch request
  function automatic int entry_cycles(input logic ls, input int wait_cyc);
    return ls ? 3 + wait_cyc : 3;
  endfunction

endpackage

// File: rtl/trap_sync.sv
module trap_sync #(
  parameter int NSIG   = 3,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSIG-1:0] din,
  output logic [NSIG-1:0] dout
);

  logic [STAGES-1:0][NSIG-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= din;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/trap_arb.sv
module trap_arb
  import trap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCLS-1:0] req,
  input  logic [NCLS-1:0] en,
  input  logic [NCLS-1:0] blocked,
  output logic [NCLS-1:0] grant,
  output logic            any
);

  logic [NCLS-1:0] ok;

  assign ok    = req & en & ~blocked;
  assign grant = pick_high(ok);
  assign any   = |ok;

  p_grant_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  for (genvar g = 0; g < NCLS; g++) begin : g_chk
    p_grant_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
      grant[g] |-> (en[g] && req[g]));
  end

endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import trap_pkg::*;
#(
  parameter int LS_WAIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_ls,
  output logic idle,
  output logic drain,
  output logic flush,
  output logic save_en,
  output logic issue
);

  localparam int CW = $clog2(LS_WAIT + 2);

  seq_st_e       st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          if (start_ls && (LS_WAIT > 0)) begin
            st  <= ST_DRAIN;
            cnt <= CW'(LS_WAIT);
          end else begin
            st <= ST_FLUSH;
          end
        end
        ST_DRAIN: begin
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) st <= ST_FLUSH;
        end
        ST_FLUSH: st <= ST_SAVE;
        ST_SAVE:  st <= ST_ISSUE;
        ST_ISSUE: st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  assign idle    = (st == ST_IDLE);
  assign drain   = (st == ST_DRAIN);
  assign flush   = (st == ST_FLUSH);
  assign save_en = (st == ST_SAVE);
  assign issue   = (st == ST_ISSUE);

  // drain window length checker
  logic [CW:0] dlen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dlen <= '0;
    else if (drain) dlen <= dlen + 1'b1;
    else            dlen <= '0;
  end

  p_drain_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drain) |-> (dlen == (CW+1)'(LS_WAIT)));

  p_flush_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> $past(flush, 2));

  p_flush_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !$past(flush));

endmodule

// File: rtl/trap_save_bank.sv
module trap_save_bank
  import trap_pkg::*;
#(
  parameter int AW = 32,
  parameter int MW = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCLS-1:0]          wr_en,
  input  logic [AW-1:0]            pc_in,
  input  logic [MW-1:0]            msr_in,
  output logic [NCLS-1:0][AW-1:0]  pc_q,
  output logic [NCLS-1:0][MW-1:0]  msr_q
);

  for (genvar g = 0; g < NCLS; g++) begin : g_pair
    logic [AW-1:0] pc_r;
    logic [MW-1:0] msr_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pc_r  <= '0;
        msr_r <= '0;
      end else if (wr_en[g]) begin
        pc_r  <= pc_in;
        msr_r <= msr_in;
      end
    end

    assign pc_q[g]  = pc_r;
    assign msr_q[g] = msr_r;

    p_pair_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en[g] |=> ($stable(pc_q[g]) && $stable(msr_q[g])));
  end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int AW          = 32,
  parameter int MW          = 32,
  parameter int SYNC_STAGES = 2,
  parameter int LS_WAIT     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_nc_in,
  input  logic          irq_cr_in,
  input  logic          irq_mc_in,
  input  logic          oldest_is_ls,
  input  logic [AW-1:0] cur_pc,
  input  logic [MW-1:0] cur_msr,
  input  logic          ret_nc,
  input  logic          ret_cr,
  input  logic          ret_mc,
  output logic          busy,
  output logic          ls_drain,
  output logic          flush,
  output logic          vec_req,
  output logic [1:0]    vec_class,
  output logic [2:0]    in_svc,
  output logic [AW-1:0] nc_save_pc,
  output logic [MW-1:0] nc_save_msr,
  output logic [AW-1:0] cr_save_pc,
  output logic [MW-1:0] cr_save_msr,
  output logic [AW-1:0] mc_save_pc,
  output logic [MW-1:0] mc_save_msr,
  output logic          pc_wr,
  output logic [AW-1:0] pc_new,
  output logic          msr_wr,
  output logic [MW-1:0] msr_new
);

  // ---- request synchronization and qualification
  logic [NCLS-1:0] raw_req, req_s, en_bits, grant, inserv_q;
  logic            grant_any;

  assign raw_req = {irq_mc_in, irq_cr_in, irq_nc_in};
  assign en_bits = {cur_msr[EN_MC], cur_msr[EN_CR], cur_msr[EN_NC]};

  trap_sync #(.NSIG(NCLS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (rst_n), .din (raw_req), .dout (req_s)
  );

  trap_arb u_arb (
    .clk (clk), .rst_n (rst_n), .req (req_s), .en (en_bits),
    .blocked (inserv_q), .grant (grant), .any (grant_any)
  );

  // ---- entry sequencer
  logic seq_idle, seq_drain, seq_flush, seq_save, seq_issue, seq_start;

  assign seq_start = grant_any && seq_idle;

  trap_seq #(.LS_WAIT(LS_WAIT)) u_seq (
    .clk (clk), .rst_n (rst_n), .start (seq_start), .start_ls (oldest_is_ls),
    .idle (seq_idle), .drain (seq_drain), .flush (seq_flush),
    .save_en (seq_save), .issue (seq_issue)
  );

  trap_cls_e cls_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cls_q <= CLS_NC;
    else if (seq_start) cls_q <= grant_to_cls(grant);
  end

  // ---- per-class save pairs
  logic [NCLS-1:0]         save_wr;
  logic [NCLS-1:0][AW-1:0] sv_pc;
  logic [NCLS-1:0][MW-1:0] sv_msr;

  assign save_wr = seq_save ? cls_onehot(cls_q) : '0;

  trap_save_bank #(.AW(AW), .MW(MW)) u_bank (
    .clk (clk), .rst_n (rst_n), .wr_en (save_wr), .pc_in (cur_pc),
    .msr_in (cur_msr), .pc_q (sv_pc), .msr_q (sv_msr)
  );

  // ---- return selection (idle only, highest class wins)
  logic [NCLS-1:0] ret_sel;
  logic [AW-1:0]   ret_pc;
  logic [MW-1:0]   ret_msr;

  assign ret_sel = seq_idle ? pick_high({ret_mc, ret_cr, ret_nc}) : '0;

  always_comb begin
    ret_pc  = '0;
    ret_msr = '0;
    for (int i = 0; i < NCLS; i++) begin
      if (ret_sel[i]) begin
        ret_pc  = sv_pc[i];
        ret_msr = sv_msr[i];
      end
    end
  end

  // ---- in-service flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inserv_q <= '0;
    else        inserv_q <= (inserv_q | save_wr) & ~ret_sel;
  end

  // ---- state write-back
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_wr   <= 1'b0;
      msr_wr  <= 1'b0;
      pc_new  <= '0;
      msr_new <= '0;
    end else begin
      pc_wr  <= 1'b0;
      msr_wr <= 1'b0;
      if (seq_save) begin
        msr_wr  <= 1'b1;
        msr_new <= cur_msr & ~MW'(en_mask_for(cls_q));
      end else if (|ret_sel) begin
        pc_wr   <= 1'b1;
        msr_wr  <= 1'b1;
        pc_new  <= ret_pc;
        msr_new <= ret_msr;
      end
    end
  end

  assign busy        = !seq_idle;
  assign ls_drain    = seq_drain;
  assign flush       = seq_flush;
  assign vec_req     = seq_issue;
  assign vec_class   = cls_q;
  assign in_svc      = inserv_q;
  assign nc_save_pc  = sv_pc[CLS_NC];
  assign nc_save_msr = sv_msr[CLS_NC];
  assign cr_save_pc  = sv_pc[CLS_CR];
  assign cr_save_msr = sv_msr[CLS_CR];
  assign mc_save_pc  = sv_pc[CLS_MC];
  assign mc_save_msr = sv_msr[CLS_MC];

  p_entry_msr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> (msr_wr && !pc_wr));

  p_ret_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr |-> $past(seq_idle));

  p_no_reentry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_save |-> !inserv_q[cls_q]);

endmodule

// File: tb/trap_entry_unit_bench.sv
module trap_entry_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  irq_lines;
  logic [2:0]  ret_lines;
  logic        oldest_is_ls;
  logic [31:0] cur_pc, cur_msr;
  logic        busy, ls_drain, flush, vec_req, pc_wr, msr_wr;
  logic [1:0]  vec_class;
  logic [2:0]  in_svc;
  logic [31:0] nc_save_pc, nc_save_msr, cr_save_pc, cr_save_msr;
  logic [31:0] mc_save_pc, mc_save_msr, pc_new, msr_new;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  trap_entry_unit u_trap_entry_unit (
    .clk (clk), .rst_n (rst_n),
    .irq_nc_in (irq_lines[0]), .irq_cr_in (irq_lines[1]), .irq_mc_in (irq_lines[2]),
    .oldest_is_ls (oldest_is_ls), .cur_pc (cur_pc), .cur_msr (cur_msr),
    .ret_nc (ret_lines[0]), .ret_cr (ret_lines[1]), .ret_mc (ret_lines[2]),
    .busy (busy), .ls_drain (ls_drain), .flush (flush), .vec_req (vec_req),
    .vec_class (vec_class), .in_svc (in_svc),
    .nc_save_pc (nc_save_pc), .nc_save_msr (nc_save_msr),
    .cr_save_pc (cr_save_pc), .cr_save_msr (cr_save_msr),
    .mc_save_pc (mc_save_pc), .mc_save_msr (mc_save_msr),
    .pc_wr (pc_wr), .pc_new (pc_new), .msr_wr (msr_wr), .msr_new (msr_new)
  );

  task automatic chk(input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_lines = '0; ret_lines = '0; oldest_is_ls = 1'b0;
    cur_pc = 32'h0000_4000; cur_msr = 32'h0000_0007;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
  endtask

  function automatic logic [31:0] spc(input int c);
    case (c)
      0: return nc_save_pc;
      1: return cr_save_pc;
      default: return mc_save_pc;
    endcase
  endfunction

  function automatic logic [31:0] smsr(input int c);
    case (c)
      0: return nc_save_msr;
      1: return cr_save_msr;
      default: return mc_save_msr;
    endcase
  endfunction

  // expected winner: highest class both raised and enabled, else -1
  function automatic int exp_class(input logic [2:0] lines, input logic [2:0] en);
    for (int c = 2; c >= 0; c--) if (lines[c] && en[c]) return c;
    return -1;
  endfunction

  // bits dropped on entry: the class and all classes below it
  function automatic logic [31:0] drop_mask(input int c);
    return (32'd1 << (c + 1)) - 32'd1;
  endfunction

  task automatic run_entry(input logic [2:0] lines, input bit ls,
                           input logic [31:0] msr, input string rq);
    int ec, lat, flush_at, flushes, drains;
    bit seen, overlap;
    logic [31:0] prev;
    ec = exp_class(lines, msr[2:0]);
    cur_msr = msr; oldest_is_ls = ls; irq_lines = lines;
    lat = 0; flush_at = -1; flushes = 0; drains = 0; seen = 0; overlap = 0;
    prev = cur_pc;
    for (int k = 0; k < 14 && !seen; k++) begin
      prev = cur_pc;
      tick();
      lat++;
      if (flush) begin flush_at = lat; flushes++; end
      if (ls_drain) drains++;
      if (flush && ls_drain) overlap = 1;
      if (vec_req) seen = 1;
      else cur_pc = cur_pc + 32'h44;
    end
    if (ec < 0) begin
      chk(rq, "no entry when disabled (R5)", seen, 0);
    end else begin
      chk(rq, "entry latency (R1/R2)", lat, ls ? 9 : 5);
      chk(rq, "drain cycles (R2)", drains, ls ? 4 : 0);
      chk(rq, "flush two before vec_req (R3)", flush_at, lat - 2);
      chk(rq, "single flush (R3)", flushes, 1);
      chk(rq, "flush outside drain (R3)", overlap, 0);
      chk(rq, "class code (R4)", vec_class, ec);
      chk(rq, "entry msr write (R7)", msr_wr, 1);
      chk(rq, "entry msr value (R7)", msr_new, msr & ~drop_mask(ec));
      chk(rq, "saved pc (R6)", spc(ec), prev);
      chk(rq, "saved msr (R6)", smsr(ec), msr);
      chk(rq, "in service set (R8)", in_svc[ec], 1);
    end
    irq_lines = '0;
    tick();
    chk(rq, "vec_req one cycle (R1)", vec_req, 0);
  endtask

  task automatic do_return(input int c, input string rq);
    logic [31:0] epc, emsr;
    epc = spc(c); emsr = smsr(c);
    ret_lines = 3'b001 << c;
    tick();
    ret_lines = '0;
    chk(rq, "restore pc strobe (R9)", pc_wr, 1);
    chk(rq, "restore msr strobe (R9)", msr_wr, 1);
    chk(rq, "restored pc (R9)", pc_new, epc);
    chk(rq, "restored msr (R9)", msr_new, emsr);
    chk(rq, "in service cleared (R9)", in_svc[c], 0);
    tick();
    chk(rq, "restore strobe one cycle (R9)", pc_wr, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // reset state
    chk("reset", "vec_req", vec_req, 0);
    chk("reset", "flush", flush, 0);
    chk("reset", "busy", busy, 0);
    chk("reset", "in_svc", in_svc, 0);
    chk("reset", "pc_wr", pc_wr, 0);
    chk("reset", "saved pairs", {nc_save_pc, cr_save_msr, mc_save_pc}, 0);

    // each class, with and without load/store drain, then its return
    for (int c = 0; c < 3; c++) begin
      for (int ls = 0; ls < 2; ls++) begin
        do_reset();
        cur_pc = 32'h1000_0000 + 32'(c * 32'h100 + ls * 32'h10);
        run_entry(3'b001 << c, ls[0], 32'h0000_5A07 ^ (32'(c) << 8), "R1/R2/R6");
        for (int j = 0; j < 3; j++)
          if (j != c) chk("R6", "other pair untouched", spc(j), 0);
        cur_msr = 32'h0000_0001;
        do_return(c, "R9");
      end
    end

    // priority and enable sweep
    for (int lines = 1; lines < 8; lines++) begin
      for (int en = 0; en < 8; en++) begin
        do_reset();
        run_entry(3'(lines), 1'b0, 32'h0000_3C00 | 32'(en), "R4/R5");
      end
    end

    // R8: in-service class is blocked until its return
    begin
      int got;
      do_reset();
      run_entry(3'b001, 1'b0, 32'h0000_0007, "R8");
      irq_lines = 3'b001;
      got = 0;
      for (int k = 0; k < 12; k++) begin tick(); if (vec_req) got++; end
      chk("R8", "no re-entry while in service", got, 0);
      do_return(0, "R8");
      got = 0;
      for (int k = 0; k < 10 && got == 0; k++) begin tick(); if (vec_req) got = 1; end
      chk("R8", "re-entry after return", got, 1);
      chk("R8", "re-entry class", vec_class, 0);
      irq_lines = '0;
      tick();
    end

    // R10: return while busy is ignored
    do_reset();
    run_entry(3'b010, 1'b0, 32'h0000_0007, "R10");
    irq_lines = 3'b001;
    repeat (3) tick();
    chk("R10", "busy during entry", busy, 1);
    ret_lines = 3'b010;
    tick();
    ret_lines = '0;
    chk("R10", "ignored return no pc_wr", pc_wr, 0);
    chk("R10", "critical still in service", in_svc[1], 1);
    tick();
    chk("R10", "noncritical entry goes on", vec_req, 1);
    chk("R10", "noncritical class", vec_class, 0);
    irq_lines = '0;
    tick();

    // R11: machine check raised during a noncritical entry
    do_reset();
    cur_msr = 32'h0000_0107;
    irq_lines = 3'b001;
    repeat (3) tick();
    chk("R11", "noncritical flush", flush, 1);
    irq_lines = 3'b101;
    repeat (2) tick();
    chk("R11", "noncritical vec_req", vec_req, 1);
    chk("R11", "noncritical class", vec_class, 0);
    irq_lines = 3'b100;
    for (int k = 1; k < 4; k++) begin
      tick();
      chk("R11", "no early vec_req", vec_req, 0);
    end
    tick();
    chk("R11", "machine check vec_req", vec_req, 1);
    chk("R11", "machine check class", vec_class, 2);
    chk("R11", "machine check msr", msr_new, 32'h0000_0100);
    irq_lines = '0;
    tick();

    // R12: return strobe in the same cycle a new request is sampled
    do_reset();
    cur_pc = 32'h2222_0000;
    run_entry(3'b010, 1'b0, 32'h0000_0007, "R12");
    begin
      logic [31:0] cpc;
      cpc = cr_save_pc;
      irq_lines = 3'b001;
      repeat (2) tick();
      ret_lines = 3'b010;
      tick();
      ret_lines = '0;
      chk("R12", "return honored", pc_wr, 1);
      chk("R12", "return pc", pc_new, cpc);
      chk("R12", "entry flushing", flush, 1);
      repeat (2) tick();
      chk("R12", "entry vec_req on time", vec_req, 1);
      chk("R12", "entry class", vec_class, 0);
      chk("R12", "critical freed", in_svc[1], 0);
      irq_lines = '0;
      tick();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule